// File: doc/BRIEF.md
# 64-bit Extended Region Classifier

This block sorts a 64-bit virtual address into one of the extended regions: the extended user region, the extended supervisor region, the direct physical window and the extended kernel region. It then applies the permission rules of that region. Each request ends in one of four ways. It can be refused as a bad address. It can be forwarded for TLB translation. It can resolve to an unmapped physical address. It can be passed back as a sign-extended 32-bit compatibility address, which the 32-bit segment logic handles.

The physical window is the region with the most rules. Address bits [61:59] select one of eight sub-windows. A per-window enable vector decides whether that sub-window takes its access mode from a configured field or uses mode 0. The chosen mode must be allowed by one of the three status enables. It is then decoded against the current privilege level, with the error-level unmapped override forced off.

The classifier is combinational and feeds one output register. Results therefore appear one clock after the request is presented. The segment-size mask and the physical-address mask are inputs that stay stable while a request is in flight.

Top module: `xreg_classify`

## Requirements
- R1: While rst_ni is low, valid_o, kind_o and paddr_o are all zero.
- R2: valid_o equals valid_i delayed by one clock. kind_o and paddr_o load only when valid_i is high and hold their values otherwise. Result codes on kind_o are 0 = bad address, 1 = TLB, 2 = unmapped, 3 = compatibility.
- R3: An address whose bits [63:31] are all zero or all one gives result 3.
- R4: An address with bits [63:62] = 00 that is outside the compatibility range gives TLB only when ux_i is set and the address is at most 0x3FFFFFFFFFFFFFFF & seg_mask_i. Any other such address gives bad address.
- R5: An address with bits [63:62] = 01 gives TLB only when three conditions hold: priv_i is not user, sx_i is set, and the address is at most 0x7FFFFFFFFFFFFFFF & seg_mask_i. Any other such address gives bad address. Privilege codes are 0 = kernel, 1 = supervisor, 2 = user, 3 = error level.
- R6: An address with bits [63:62] = 11 that is outside the compatibility range gives TLB only when three conditions hold: priv_i is kernel or error level, kx_i is set, and the address is at most 0xFFFFFFFF7FFFFFFF & seg_mask_i. Any other such address gives bad address.
- R7: An address with bits [63:62] = 10 is in the physical window. If its bits [58:0] exceed pa_mask_i, the result is bad address.
- R8: In the window, the access mode is ctl1_lo_i[6:4] when bit vaddr[61:59] of ctl2_lo_i[7:0] is set, and 0 otherwise.
- R9: Modes 0, 1 and 6 require kx_i. Modes 2 and 5 require sx_i. Modes 3, 4 and 7 require ux_i. If the required enable is clear, the result is bad address.
- R10: A permitted mode is decoded by privilege. Kernel and error level: modes 1, 2 and 3 give TLB, and all other modes are unmapped. Supervisor: modes 0 and 1 give bad address, modes 2, 3 and 4 give TLB, and modes 5, 6 and 7 are unmapped. User: modes 0, 1, 2 and 5 give bad address, modes 3 and 4 give TLB, and modes 6 and 7 are unmapped.
- R11: An unmapped result gives paddr_o = vaddr & pa_mask_i. Every other result gives paddr_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present |
| vaddr_i | input | 64 | Virtual address |
| priv_i | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user, 3 error level |
| ux_i | input | 1 | User extended enable |
| sx_i | input | 1 | Supervisor extended enable |
| kx_i | input | 1 | Kernel extended enable |
| seg_mask_i | input | 64 | Segment-size mask |
| pa_mask_i | input | 64 | Physical-address mask |
| ctl1_lo_i | input | 16 | Control 1 lower half; window mode in [6:4] |
| ctl2_lo_i | input | 16 | Control 2 lower half; per-window enables in [7:0] |
| valid_o | output | 1 | Result present |
| kind_o | output | 2 | Result code: 0 bad, 1 TLB, 2 unmapped, 3 compatibility |
| paddr_o | output | 64 | Physical address when unmapped, else 0 |

## Verification
Some properties are checked on every cycle. The one-cycle valid delay is one. Another is that the physical address is zero for every non-unmapped result and stays within the physical mask when unmapped. The others are that compatibility addresses always give result 3, and that user or supervisor requests to the supervisor or kernel extended regions are refused.

Other behaviour needs the directed scenarios. These cover the exact segment-size and physical-mask boundaries, the selection of the per-window mode, the mode-to-enable table and the privilege decode for every mode.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  typedef enum logic [1:0] {
    RES_FAULT  = 2'd0,
    RES_TLB    = 2'd1,
    RES_UNMAP  = 2'd2,
    RES_COMPAT = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    PRV_KERN  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_USER  = 2'd2,
    PRV_ERR   = 2'd3
  } prv_e;
endpackage

// File: rtl/xreg_am_dec.sv
module xreg_am_dec
  import xreg_pkg::*;
#(
  parameter int unsigned AM_W = 3
) (
  input  logic [AM_W-1:0] am_i,
  input  logic [1:0]      priv_i,
  output logic            fault_o,
  output logic            mapped_o
);
  localparam int unsigned NUM_AM = 1 << AM_W;

  // per-privilege fault and mapped sets, bit n = mode n
  localparam logic [NUM_AM-1:0] K_MAP = NUM_AM'(8'b0000_1110);
  localparam logic [NUM_AM-1:0] S_BAD = NUM_AM'(8'b0000_0011);
  localparam logic [NUM_AM-1:0] S_MAP = NUM_AM'(8'b0001_1100);
  localparam logic [NUM_AM-1:0] U_BAD = NUM_AM'(8'b0010_0111);
  localparam logic [NUM_AM-1:0] U_MAP = NUM_AM'(8'b0001_1000);

  always_comb begin
    fault_o  = 1'b0;
    mapped_o = 1'b0;
    unique case (priv_i)
      PRV_SUPER: begin
        fault_o  = S_BAD[am_i];
        mapped_o = S_MAP[am_i];
      end
      PRV_USER: begin
        fault_o  = U_BAD[am_i];
        mapped_o = U_MAP[am_i];
      end
      default: mapped_o = K_MAP[am_i]; // kernel and error level, EU forced off
    endcase
  end
endmodule

// File: rtl/xreg_win_mode.sv
module xreg_win_mode #(
  parameter int unsigned WIN_W   = 3,
  parameter int unsigned AM_W    = 3,
  parameter int unsigned XAM_LSB = 4
) (
  input  logic [WIN_W-1:0]      win_i,
  input  logic [15:0]           ctl1_lo_i,
  input  logic [15:0]           ctl2_lo_i,
  input  logic                  ux_i,
  input  logic                  sx_i,
  input  logic                  kx_i,
  output logic [AM_W-1:0]       am_o,
  output logic                  perm_ok_o
);
  localparam int unsigned NUM_WIN = 1 << WIN_W;
  localparam int unsigned NUM_AM  = 1 << AM_W;

  localparam logic [NUM_AM-1:0] NEED_K = NUM_AM'(8'b0100_0011);
  localparam logic [NUM_AM-1:0] NEED_S = NUM_AM'(8'b0010_0100);
  localparam logic [NUM_AM-1:0] NEED_U = NUM_AM'(8'b1001_1000);

  logic [NUM_WIN-1:0] win_en;
  logic [AM_W-1:0]    xam;

  assign win_en = ctl2_lo_i[NUM_WIN-1:0];
  assign xam    = ctl1_lo_i[XAM_LSB +: AM_W];
  assign am_o   = win_en[win_i] ? xam : '0;

  assign perm_ok_o = (NEED_K[am_o] & kx_i) |
                     (NEED_S[am_o] & sx_i) |
                     (NEED_U[am_o] & ux_i);
endmodule

// File: rtl/xreg_region_dec.sv
module xreg_region_dec
  import xreg_pkg::*;
#(
  parameter int unsigned WIN_W = 3,
  parameter int unsigned AM_W  = 3
) (
  input  logic [63:0] vaddr_i,
  input  logic [1:0]  priv_i,
  input  logic        ux_i,
  input  logic        sx_i,
  input  logic        kx_i,
  input  logic [63:0] seg_mask_i,
  input  logic [63:0] pa_mask_i,
  input  logic [15:0] ctl1_lo_i,
  input  logic [15:0] ctl2_lo_i,
  output res_e        kind_o,
  output logic [63:0] paddr_o
);
  localparam logic [63:0] XU_TOP  = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] XS_TOP  = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] XK_TOP  = 64'hFFFF_FFFF_7FFF_FFFF;
  localparam logic [63:0] WIN_OFF = 64'h07FF_FFFF_FFFF_FFFF;
  localparam int unsigned WIN_LSB = 59;

  logic            compat, is_kern, is_super_up;
  logic [AM_W-1:0] am;
  logic            perm_ok, am_fault, am_mapped;

  assign compat      = (vaddr_i[63:31] == '0) | (&vaddr_i[63:31]);
  assign is_kern     = (priv_i == PRV_KERN) | (priv_i == PRV_ERR);
  assign is_super_up = (priv_i != PRV_USER);

  xreg_win_mode #(.WIN_W(WIN_W), .AM_W(AM_W)) u_win (
    .win_i     (vaddr_i[WIN_LSB +: WIN_W]),
    .ctl1_lo_i (ctl1_lo_i),
    .ctl2_lo_i (ctl2_lo_i),
    .ux_i      (ux_i),
    .sx_i      (sx_i),
    .kx_i      (kx_i),
    .am_o      (am),
    .perm_ok_o (perm_ok)
  );

  xreg_am_dec #(.AM_W(AM_W)) u_am (
    .am_i     (am),
    .priv_i   (priv_i),
    .fault_o  (am_fault),
    .mapped_o (am_mapped)
  );

  always_comb begin
    kind_o  = RES_FAULT;
    paddr_o = '0;
    if (compat) begin
      kind_o = RES_COMPAT;
    end else begin
      unique case (vaddr_i[63:62])
        2'b00: if (ux_i && vaddr_i <= (XU_TOP & seg_mask_i)) kind_o = RES_TLB;
        2'b01: if (is_super_up && sx_i && vaddr_i <= (XS_TOP & seg_mask_i)) kind_o = RES_TLB;
        2'b11: if (is_kern && kx_i && vaddr_i <= (XK_TOP & seg_mask_i)) kind_o = RES_TLB;
        default: begin
          if ((vaddr_i & WIN_OFF) <= pa_mask_i && perm_ok && !am_fault) begin
            if (am_mapped) begin
              kind_o = RES_TLB;
            end else begin
              kind_o  = RES_UNMAP;
              paddr_o = vaddr_i & pa_mask_i;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xreg_classify.sv
module xreg_classify
  import xreg_pkg::*;
#(
  parameter int unsigned WIN_W = 3,
  parameter int unsigned AM_W  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [63:0] vaddr_i,
  input  logic [1:0]  priv_i,
  input  logic        ux_i,
  input  logic        sx_i,
  input  logic        kx_i,
  input  logic [63:0] seg_mask_i,
  input  logic [63:0] pa_mask_i,
  input  logic [15:0] ctl1_lo_i,
  input  logic [15:0] ctl2_lo_i,
  output logic        valid_o,
  output logic [1:0]  kind_o,
  output logic [63:0] paddr_o
);
  res_e        kind_d;
  logic [63:0] paddr_d;

  xreg_region_dec #(.WIN_W(WIN_W), .AM_W(AM_W)) u_dec (
    .vaddr_i    (vaddr_i),
    .priv_i     (priv_i),
    .ux_i       (ux_i),
    .sx_i       (sx_i),
    .kx_i       (kx_i),
    .seg_mask_i (seg_mask_i),
    .pa_mask_i  (pa_mask_i),
    .ctl1_lo_i  (ctl1_lo_i),
    .ctl2_lo_i  (ctl2_lo_i),
    .kind_o     (kind_d),
    .paddr_o    (paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= 2'd0;
      paddr_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        kind_o  <= kind_d;
        paddr_o <= paddr_d;
      end
    end
  end
endmodule

// File: rtl/xreg_classify_chk.sv
module xreg_classify_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [63:0] vaddr_i,
  input logic [1:0]  priv_i,
  input logic [63:0] pa_mask_i,
  input logic        valid_o,
  input logic [1:0]  kind_o,
  input logic [63:0] paddr_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  // R11
  paddr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o != 2'd2 |-> paddr_o == '0);

  // R11
  paddr_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && kind_o == 2'd2) |-> (paddr_o & ~$past(pa_mask_i)) == '0);

  // R3
  compat_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && (($past(vaddr_i[63:31]) == '0) || (&$past(vaddr_i[63:31]))))
      |-> kind_o == 2'd3);

  // R5
  user_xsseg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(priv_i) == 2'd2 && $past(vaddr_i[63:62]) == 2'b01)
      |-> kind_o == 2'd0);

  // R6
  nonkern_xkseg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && ($past(priv_i) == 2'd1 || $past(priv_i) == 2'd2) &&
     $past(vaddr_i[63:62]) == 2'b11 && !(&$past(vaddr_i[63:31])))
      |-> kind_o == 2'd0);
endmodule

bind xreg_classify xreg_classify_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .vaddr_i   (vaddr_i),
  .priv_i    (priv_i),
  .pa_mask_i (pa_mask_i),
  .valid_o   (valid_o),
  .kind_o    (kind_o),
  .paddr_o   (paddr_o)
);

// File: tb/xreg_classify_tb.sv
module xreg_classify_tb;
  localparam logic [1:0] K_BAD = 2'd0, K_TLB = 2'd1, K_UNM = 2'd2, K_CMP = 2'd3;
  localparam logic [63:0] SEGM = 64'hC000_00FF_FFFF_FFFF;
  localparam logic [63:0] PAM  = 64'h0000_000F_FFFF_FFFF;
  localparam logic [63:0] WBASE = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [63:0] vaddr = '0;
  logic [1:0]  priv = 2'd0;
  logic        ux = 1'b1, sx = 1'b1, kx = 1'b1;
  logic [63:0] seg_mask = SEGM;
  logic [63:0] pa_mask = PAM;
  logic [15:0] ctl1 = '0, ctl2 = '0;
  logic        valid_o;
  logic [1:0]  kind_o;
  logic [63:0] paddr_o;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  xreg_classify u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .vaddr_i(vaddr), .priv_i(priv),
    .ux_i(ux), .sx_i(sx), .kx_i(kx), .seg_mask_i(seg_mask), .pa_mask_i(pa_mask),
    .ctl1_lo_i(ctl1), .ctl2_lo_i(ctl2), .valid_o(valid_o), .kind_o(kind_o), .paddr_o(paddr_o)
  );

  task automatic run(input logic [63:0] a, input logic [1:0] ek, input logic [63:0] ep,
                     input string tag);
    @(negedge clk);
    vaddr = a;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    nchk++;
    if (valid_o !== 1'b1 || kind_o !== ek || paddr_o !== ep) begin
      nfail++;
      $display("FAIL %s addr=%h got v=%b k=%0d pa=%h exp v=1 k=%0d pa=%h",
               tag, a, valid_o, kind_o, paddr_o, ek, ep);
    end
  endtask

  // expected window result from the R9/R10 tables
  function automatic logic [1:0] win_exp(input logic [1:0] p, input int am,
                                         input logic u, input logic s, input logic k);
    logic need;
    case (am)
      0, 1, 6: need = k;
      2, 5:    need = s;
      default: need = u;
    endcase
    if (!need) return K_BAD;
    case (p)
      2'd1: begin
        if (am <= 1) return K_BAD;
        if (am <= 4) return K_TLB;
        return K_UNM;
      end
      2'd2: begin
        if (am <= 2 || am == 5) return K_BAD;
        if (am <= 4) return K_TLB;
        return K_UNM;
      end
      default: return (am >= 1 && am <= 3) ? K_TLB : K_UNM;
    endcase
  endfunction

  task automatic t_reset;
    #3;
    nchk++;
    if (valid_o !== 1'b0 || kind_o !== 2'd0 || paddr_o !== '0) begin
      nfail++;
      $display("FAIL R1 got v=%b k=%0d pa=%h exp all zero", valid_o, kind_o, paddr_o);
    end
  endtask

  task automatic t_compat;
    priv = 2'd0;
    run(64'h0000_0000_7FFF_FFFF, K_CMP, '0, "R3 low");
    run(64'hFFFF_FFFF_8000_0000, K_CMP, '0, "R3 high");
    run(64'hFFFF_FFFF_FFFF_FFFF, K_CMP, '0, "R3 top");
  endtask

  task automatic t_xuseg;
    priv = 2'd2; ux = 1'b1;
    run(64'h0000_0000_8000_0000, K_TLB, '0, "R4 first");
    run(64'h0000_00FF_FFFF_FFFF, K_TLB, '0, "R4 limit");
    run(64'h0000_0100_0000_0000, K_BAD, '0, "R4 over");
    ux = 1'b0;
    run(64'h0000_0000_8000_0000, K_BAD, '0, "R4 ux off");
    ux = 1'b1;
  endtask

  task automatic t_xsseg;
    priv = 2'd1; sx = 1'b1;
    run(64'h4000_00FF_FFFF_FFFF, K_TLB, '0, "R5 super limit");
    run(64'h4000_0100_0000_0000, K_BAD, '0, "R5 over");
    priv = 2'd0;
    run(64'h4000_0000_0000_0000, K_TLB, '0, "R5 kernel");
    priv = 2'd2;
    run(64'h4000_0000_0000_0000, K_BAD, '0, "R5 user");
    priv = 2'd1; sx = 1'b0;
    run(64'h4000_0000_0000_0000, K_BAD, '0, "R5 sx off");
    sx = 1'b1;
  endtask

  task automatic t_xkseg;
    priv = 2'd0; kx = 1'b1;
    run(64'hC000_00FF_7FFF_FFFF, K_TLB, '0, "R6 limit");
    run(64'hC000_00FF_8000_0000, K_BAD, '0, "R6 over");
    run(64'hFFFF_FFFF_7FFF_FFFF, K_BAD, '0, "R6 below compat");
    priv = 2'd3;
    run(64'hC000_0000_0000_0000, K_TLB, '0, "R6 err level");
    priv = 2'd1;
    run(64'hC000_0000_0000_0000, K_BAD, '0, "R6 super");
    priv = 2'd0; kx = 1'b0;
    run(64'hC000_0000_0000_0000, K_BAD, '0, "R6 kx off");
    kx = 1'b1;
  endtask

  task automatic t_window_bound;
    priv = 2'd0; ctl2 = '0; ctl1 = 16'h0070;
    run(WBASE | PAM, K_UNM, PAM, "R7 at mask");
    run(WBASE | (PAM + 64'd1), K_BAD, '0, "R7 over mask");
    run(WBASE | (64'd3 << 59) | 64'h1234, K_UNM, 64'h1234, "R8 enable clear mode 0");
    // R2: outputs hold while valid_i is low
    @(negedge clk);
    nchk++;
    if (valid_o !== 1'b0 || kind_o !== K_UNM || paddr_o !== 64'h1234) begin
      nfail++;
      $display("FAIL R2 idle got v=%b k=%0d pa=%h exp v=0 k=2 pa=1234", valid_o, kind_o, paddr_o);
    end
  endtask

  task automatic t_window_modes;
    for (int p = 0; p < 4; p++) begin
      for (int am = 0; am < 8; am++) begin
        for (int v = 0; v < 2; v++) begin
          logic [63:0] a;
          logic [1:0]  ek;
          logic [63:0] ep;
          logic        u, s, k;
          u = 1'b1; s = 1'b1; k = 1'b1;
          if (v == 1) begin
            case (am)
              0, 1, 6: k = 1'b0;
              2, 5:    s = 1'b0;
              default: u = 1'b0;
            endcase
          end
          priv = 2'(p); ux = u; sx = s; kx = k;
          ctl2 = 16'(1 << am);
          ctl1 = 16'(am << 4);
          a  = WBASE | (64'(am) << 59) | 64'h0ABC_DEF0;
          ek = win_exp(2'(p), am, u, s, k);
          ep = (ek == K_UNM) ? 64'h0ABC_DEF0 : '0;
          run(a, ek, ep, $sformatf("R9 R10 priv=%0d mode=%0d gate=%0d", p, am, v));
        end
      end
    end
    ux = 1'b1; sx = 1'b1; kx = 1'b1; priv = 2'd2;
    ctl1 = 16'h0070;
    ctl2 = 16'h00FE;
    run(WBASE | 64'h55, K_BAD, '0, "R8 window 0 disabled user mode 0");
    ctl2 = 16'h0001;
    run(WBASE | 64'h55, K_UNM, 64'h55, "R8 window 0 enabled user mode 7");
    run(WBASE | (64'd1 << 59) | 64'h55, K_BAD, '0, "R8 other window disabled");
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_compat();
    t_xuseg();
    t_xsseg();
    t_xkseg();
    t_window_bound();
    t_window_modes();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule